// File: doc/BRIEF.md
# Interrupt Cause Aggregator

This block gathers interrupt causes into one cause register, `DATA_W` bits wide. A cause bit can be set in three ways: a one-cycle pulse from the calculation engine, a one-cycle pulse from the transfer engine, or a software write to the set register. Software clears causes by writing a mask to the clear register. The host reads the accumulated causes through a small register port. A read returns its data one cycle after the request.

The block signals the host in one of two ways, chosen by `msi_en_i`. When message-signalled interrupts are off, a level-sensitive legacy line is asserted while causes are pending. When they are on, every raise event emits a one-cycle request pulse to an external message transport, and the legacy line is left as it was. Both outputs are registered.

Top module: `intc_cause_agg`

## Requirements
- R1: A read of offset 0x24 returns the cause register in `rd_data_o` on the cycle after `rd_en_i`. A read of any other offset returns all ones.
- R2: A write to offset 0x60 ORs `wr_data_i` into the cause register.
- R3: A pulse on `calc_done_i` sets cause bit 0 (value 0x00000001). A pulse on `xfer_done_i` sets cause bit 8 (value 0x00000100).
- R4: A raise event is a write to 0x60 (its data may be zero) or any hardware pulse. If the register is non-zero after the raise, the block acts on the following cycle. With `msi_en_i` high, `msi_req_o` is high for exactly one cycle. With `msi_en_i` low, `legacy_irq_o` is asserted.
- R5: A write to offset 0x64 clears the cause bits that are set in `wr_data_i`. `legacy_irq_o` falls only if the register becomes zero while `msi_en_i` is low. While `msi_en_i` is high, `legacy_irq_o` keeps its value.
- R6: Each raise event gives its own pulse on `msi_req_o`, even when the bits it sets were already set. `msi_req_o` is never high unless `msi_en_i` was high in the previous cycle.
- R7: Synchronous reset clears the cause register, `legacy_irq_o` and `msi_req_o`.
- R8: If a hardware pulse and a clear write touch the same bit in one cycle, the hardware pulse wins and the bit stays set. Other bits named in the clear mask are still cleared.
- R9: A write to any offset other than 0x60 or 0x64 leaves the cause register and both interrupt outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write byte offset |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | ADDR_W | Read byte offset |
| rd_data_o | output | DATA_W | Read data, registered |
| calc_done_i | input | 1 | Calculation-complete pulse |
| xfer_done_i | input | 1 | Transfer-complete pulse |
| msi_en_i | input | 1 | Selects message-signalled mode |
| legacy_irq_o | output | 1 | Level-sensitive legacy interrupt |
| msi_req_o | output | 1 | One-cycle message interrupt request |

## Verification
Two things can land in the same cycle: a hardware completion pulse and a software clear write. The bench provokes this by driving `calc_done_i` together with a clear write whose mask covers bit 0 and bit 8. It then reads the register back and expects bit 0 to be set and bit 8 to be cleared. Because that cycle also counts as a raise that leaves the register non-zero, the bench also expects the interrupt outputs to behave as for a raise and not as for a clear to zero.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int OFS_CAUSE = 'h24;
  localparam int OFS_SET   = 'h60;
  localparam int OFS_CLR   = 'h64;

  typedef struct packed {
    logic set_wr;
    logic clr_wr;
  } intc_wr_t;
endpackage

// File: rtl/intc_regport.sv
module intc_regport
  import intc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] cause_i,
  output intc_wr_t          wr_dec_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);
  localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR);

  always_comb begin
    wr_dec_o.set_wr = wr_en_i && (wr_addr_i == A_SET);
    wr_dec_o.clr_wr = wr_en_i && (wr_addr_i == A_CLR);
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data_o <= '0;
    else if (rd_en_i)
      rd_data_o <= (rd_addr_i == A_CAUSE) ? cause_i : '1;
  end
endmodule

// File: rtl/intc_cause_reg.sv
module intc_cause_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] hw_set_i,
  input  logic [DATA_W-1:0] sw_set_i,
  input  logic [DATA_W-1:0] sw_clr_i,
  output logic [DATA_W-1:0] cause_o,
  output logic              next_nz_o
);
  logic [DATA_W-1:0] nxt;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    // a hardware pulse overrides a clear of the same bit
    assign nxt[b] = hw_set_i[b] | sw_set_i[b] | (cause_o[b] & ~sw_clr_i[b]);

    always_ff @(posedge clk) begin
      if (rst) cause_o[b] <= 1'b0;
      else     cause_o[b] <= nxt[b];
    end
  end

  assign next_nz_o = |nxt;
endmodule

// File: rtl/intc_irq_out.sv
module intc_irq_out (
  input  logic clk,
  input  logic rst,
  input  logic raise_i,
  input  logic clear_i,
  input  logic next_nz_i,
  input  logic msi_en_i,
  output logic legacy_irq_o,
  output logic msi_req_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      legacy_irq_o <= 1'b0;
      msi_req_o    <= 1'b0;
    end else begin
      msi_req_o <= raise_i && next_nz_i && msi_en_i;
      if (!msi_en_i) begin
        if (raise_i && next_nz_i)
          legacy_irq_o <= 1'b1;
        else if (clear_i && !next_nz_i)
          legacy_irq_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/intc_cause_agg.sv
module intc_cause_agg
  import intc_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CALC_BIT = 0,
  parameter int XFER_BIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              calc_done_i,
  input  logic              xfer_done_i,
  input  logic              msi_en_i,
  output logic              legacy_irq_o,
  output logic              msi_req_o
);
  intc_wr_t          wr_dec;
  logic [DATA_W-1:0] cause_q;
  logic [DATA_W-1:0] hw_set;
  logic              next_nz;

  always_comb begin
    hw_set           = '0;
    hw_set[CALC_BIT] = calc_done_i;
    hw_set[XFER_BIT] = xfer_done_i;
  end

  intc_regport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst(rst),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .cause_i(cause_q), .wr_dec_o(wr_dec), .rd_data_o(rd_data_o)
  );

  intc_cause_reg #(.DATA_W(DATA_W)) u_cause (
    .clk(clk), .rst(rst),
    .hw_set_i(hw_set),
    .sw_set_i(wr_dec.set_wr ? wr_data_i : '0),
    .sw_clr_i(wr_dec.clr_wr ? wr_data_i : '0),
    .cause_o(cause_q), .next_nz_o(next_nz)
  );

  intc_irq_out u_out (
    .clk(clk), .rst(rst),
    .raise_i(wr_dec.set_wr | calc_done_i | xfer_done_i),
    .clear_i(wr_dec.clr_wr),
    .next_nz_i(next_nz), .msi_en_i(msi_en_i),
    .legacy_irq_o(legacy_irq_o), .msi_req_o(msi_req_o)
  );
endmodule

// File: rtl/intc_cause_agg_chk.sv
module intc_cause_agg_chk #(
  parameter int DATA_W   = 32,
  parameter int CALC_BIT = 0
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] cause_q,
  input logic              calc_done_i,
  input logic              msi_en_i,
  input logic              legacy_irq_o,
  input logic              msi_req_o
);
  p_reset_clears_r7: assert property (@(posedge clk)
    rst |=> (cause_q == '0 && !legacy_irq_o && !msi_req_o));

  p_msi_needs_en_r6: assert property (@(posedge clk) disable iff (rst)
    msi_req_o |-> $past(msi_en_i));

  p_msi_pending_r4: assert property (@(posedge clk) disable iff (rst)
    msi_req_o |-> cause_q != '0);

  p_legacy_held_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(msi_en_i) && !$past(rst)) |-> legacy_irq_o == $past(legacy_irq_o));

  p_legacy_rise_pending_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(legacy_irq_o) |-> cause_q != '0);

  p_hw_wins_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(calc_done_i) && !$past(rst)) |-> cause_q[CALC_BIT]);
endmodule

bind intc_cause_agg intc_cause_agg_chk #(.DATA_W(DATA_W), .CALC_BIT(CALC_BIT)) u_chk (
  .clk(clk), .rst(rst), .cause_q(cause_q), .calc_done_i(calc_done_i),
  .msi_en_i(msi_en_i), .legacy_irq_o(legacy_irq_o), .msi_req_o(msi_req_o)
);

// File: tb/intc_cause_agg_tb_top.sv
module intc_cause_agg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          calc_done = 1'b0, xfer_done = 1'b0, msi_en = 1'b0;
  logic          legacy_irq, msi_req;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_cause_agg dut_i (
    .clk(clk), .rst(rst),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .calc_done_i(calc_done), .xfer_done_i(xfer_done), .msi_en_i(msi_en),
    .legacy_irq_o(legacy_irq), .msi_req_o(msi_req)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // each task starts and ends on a falling edge
  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    check("R7 legacy", {31'b0, legacy_irq}, 0);
    check("R7 msi", {31'b0, msi_req}, 0);
    rd('h24, v); check("R7 cause", v, 0);
  endtask

  task automatic t_set_legacy();
    logic [DW-1:0] v;
    wr('h60, 32'h5);
    check("R4 legacy up", {31'b0, legacy_irq}, 1);
    check("R4 no msi", {31'b0, msi_req}, 0);
    wr('h60, 32'h30);
    rd('h24, v); check("R2 or-in", v, 32'h35);
    rd('h00, v); check("R1 unmapped", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_other_write();
    logic [DW-1:0] v;
    wr('h24, 32'h0); wr('h20, 32'hFFFF_FFFF);
    rd('h24, v); check("R9 cause kept", v, 32'h35);
    check("R9 legacy kept", {31'b0, legacy_irq}, 1);
  endtask

  task automatic t_clear_legacy();
    logic [DW-1:0] v;
    wr('h64, 32'h31);
    rd('h24, v); check("R5 partial", v, 32'h4);
    check("R5 legacy stays", {31'b0, legacy_irq}, 1);
    wr('h64, 32'h4);
    check("R5 legacy down", {31'b0, legacy_irq}, 0);
  endtask

  task automatic t_hw();
    logic [DW-1:0] v;
    calc_done = 1'b1; @(negedge clk); calc_done = 1'b0;
    check("R3 legacy", {31'b0, legacy_irq}, 1);
    xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
    rd('h24, v); check("R3 bits", v, 32'h101);
    wr('h64, 32'hFFFF_FFFF);
    check("R5 all clear", {31'b0, legacy_irq}, 0);
  endtask

  task automatic t_msi();
    logic [DW-1:0] v;
    msi_en = 1'b1;
    wr('h60, 32'h10);
    check("R4 msi pulse", {31'b0, msi_req}, 1);
    check("R4 legacy off", {31'b0, legacy_irq}, 0);
    @(negedge clk);
    check("R4 one cycle", {31'b0, msi_req}, 0);
    wr('h60, 32'h10);
    check("R6 repeat pulse", {31'b0, msi_req}, 1);
    wr('h60, 32'h0);
    check("R6 zero-data raise", {31'b0, msi_req}, 1);
    xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
    check("R6 hw pulse", {31'b0, msi_req}, 1);
    wr('h64, 32'hFFFF_FFFF);
    check("R4 no pulse on clear", {31'b0, msi_req}, 0);
    wr('h60, 32'h0);
    check("R4 empty raise", {31'b0, msi_req}, 0);
    // legacy left alone on clear while msi enabled
    msi_en = 1'b0; wr('h60, 32'h2);
    check("R4 legacy up", {31'b0, legacy_irq}, 1);
    msi_en = 1'b1; wr('h64, 32'h2);
    rd('h24, v); check("R5 cleared", v, 0);
    check("R5 legacy held", {31'b0, legacy_irq}, 1);
    msi_en = 1'b0; wr('h60, 32'h0); wr('h64, 32'h0);
    check("R5 legacy drops", {31'b0, legacy_irq}, 0);
  endtask

  task automatic t_collide();
    logic [DW-1:0] v;
    wr('h60, 32'h101);
    calc_done = 1'b1; wr('h64, 32'h101); calc_done = 1'b0;
    rd('h24, v); check("R8 hw wins", v, 32'h1);
    check("R8 legacy stays", {31'b0, legacy_irq}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_set_legacy();
    t_other_write();
    t_clear_legacy();
    t_hw();
    t_msi();
    t_collide();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule